// File: doc/BRIEF.md
# Reference-Gated Edge Counter

This block measures the frequency of an external clock under test. It counts that clock's rising edges over exactly one period of a once-per-second timing reference. Software arms the block with a single-cycle `arm` pulse. From then on the gate is controlled only by hardware: the first reference rising edge after arming opens the gate, and the next one closes it and ends the acquisition. Software latency therefore never adds or drops counts.

The count is held in a low word of `CNT_W` bits and extended by a separate overflow word of `OVF_W` bits. The overflow word steps once each time the low word wraps. The combined total is `ovf_count * 2^CNT_W + low_count`. When the overflow word is full it stops counting and raises a sticky error flag instead of wrapping. The host pulses `clear` to zero the result before the next arm. If the host arms again without clearing, the counts accumulate.

Both inputs are sampled by the block's own system clock through a two-flop synchronizer followed by rising-edge detection. The system clock must therefore run faster than twice the frequency being measured.

Top module: `pps_gated_counter`

## Requirements
- R1: After reset, all counts are zero, and `busy`, `gate`, `done` and `ovf_err` are low.
- R2: An `arm` pulse while idle raises `busy` on the next clock edge and clears `done`. `gate` stays low until a reference rising edge arrives.
- R3: The first synchronized reference rising edge after arming raises `gate`. The second one lowers `gate` and `busy` together and sets `done`. `gate` is never high without `busy`.
- R4: The low word increases by one for each synchronized rising edge of `cut_in` seen while `gate` is high, and at no other time. A clock-under-test edge that is synchronized in the same cycle as the opening reference edge is not counted. One that is synchronized in the same cycle as the closing edge is counted.
- R5: When the low word wraps from all ones to zero, the overflow word increases by one.
- R6: `total_count` equals `ovf_count * 2^CNT_W + low_count`.
- R7: When the overflow word is at all ones and the low word wraps, the overflow word holds its value and `ovf_err` goes high. `ovf_err` stays high until `clear`.
- R8: `clear` takes priority over `arm`. On the next edge it zeroes both count words and drops `ovf_err`, `done`, `busy` and `gate`, aborting any acquisition in progress.
- R9: Reference rising edges while the block is not armed leave `gate` low and the counts unchanged.
- R10: An `arm` pulse while `busy` is high is ignored: the acquisition in progress and its gate state continue.
- R11: Arming does not zero the counts. A second acquisition without `clear` adds to the previous total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cut_in | input | 1 | Clock under test, asynchronous |
| ref_in | input | 1 | Once-per-second reference pulse, asynchronous |
| arm | input | 1 | Single-cycle request to start one acquisition |
| clear | input | 1 | Zeroes the result and aborts any acquisition |
| total_count | output | CNT_W+OVF_W | Combined count |
| low_count | output | CNT_W | Low count word |
| ovf_count | output | OVF_W | Number of low-word wraps, saturating |
| ovf_err | output | 1 | Sticky flag: the overflow word was full when a wrap arrived |
| busy | output | 1 | Armed or gating |
| gate | output | 1 | Live gate state |
| done | output | 1 | Last acquisition completed |

## Verification
`arm` and `clear` are registered directly, so their effects appear one edge after they are driven. A transition on `ref_in` or `cut_in` passes through two synchronizer flops and then the state register, so its effect on `gate`, `busy`, `done` or the counts appears on the third edge after the input is driven. The bench drives inputs on the falling edge and replays each one through a three-deep history inside its reference model. That history reproduces exactly which edge each input transition acts on. Every output is then compared with the model shortly after each rising edge. A second instance with narrow words reaches wrap and saturation within a short run.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Acquisition phase of the gate sequencer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_OPEN  = 2'd2
  } pgc_phase_e;

endpackage

// File: rtl/pgc_edge_sync.sv
module pgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  // Single-cycle pulse on a synchronized low-to-high transition
  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pgc_gate_ctrl.sv
module pgc_gate_ctrl
  import pgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic ref_rise,
  output logic busy,
  output logic gate,
  output logic done
);

  pgc_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
    end else if (clr) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (arm) begin
            phase_q <= PH_ARMED;
            done    <= 1'b0;
          end
        end
        PH_ARMED: begin
          if (ref_rise) phase_q <= PH_OPEN;
        end
        PH_OPEN: begin
          if (ref_rise) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign gate = (phase_q == PH_OPEN);

endmodule

// File: rtl/pgc_ext_counter.sv
module pgc_ext_counter #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] low,
  output logic [OVF_W-1:0] ovf,
  output logic             err,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LOW_MAX = '1;
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic ovf_full;

  assign wrap     = inc && (low == LOW_MAX);
  assign ovf_full = (ovf == OVF_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low <= '0;
      ovf <= '0;
      err <= 1'b0;
    end else if (clr) begin
      low <= '0;
      ovf <= '0;
      err <= 1'b0;
    end else if (inc) begin
      low <= low + 1'b1;
      if (wrap) begin
        if (ovf_full) err <= 1'b1;
        else          ovf <= ovf + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pps_gated_counter.sv
module pps_gated_counter #(
  parameter int CNT_W       = 16,
  parameter int OVF_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int TOT_W      = CNT_W + OVF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cut_in,
  input  logic             ref_in,
  input  logic             arm,
  input  logic             clear,
  output logic [TOT_W-1:0] total_count,
  output logic [CNT_W-1:0] low_count,
  output logic [OVF_W-1:0] ovf_count,
  output logic             ovf_err,
  output logic             busy,
  output logic             gate,
  output logic             done
);

  // Combined count: overflow word weighted by 2^CNT_W plus low word
  function automatic logic [TOT_W-1:0] join_count(input logic [OVF_W-1:0] hi,
                                                  input logic [CNT_W-1:0] lo);
    logic [TOT_W-1:0] acc;
    acc = TOT_W'(hi) << CNT_W;
    return acc + TOT_W'(lo);
  endfunction

  // Named internal events, also observed by the checker
  logic cut_rise;
  logic ref_rise;
  logic count_en;
  logic low_wrap;

  pgc_edge_sync #(.STAGES(SYNC_STAGES)) u_cut_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cut_in),
    .rise (cut_rise)
  );

  pgc_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ref_in),
    .rise (ref_rise)
  );

  pgc_gate_ctrl u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clear),
    .arm     (arm),
    .ref_rise(ref_rise),
    .busy    (busy),
    .gate    (gate),
    .done    (done)
  );

  assign count_en = gate & cut_rise;

  pgc_ext_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clear),
    .inc  (count_en),
    .low  (low_count),
    .ovf  (ovf_count),
    .err  (ovf_err),
    .wrap (low_wrap)
  );

  assign total_count = join_count(ovf_count, low_count);

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             arm,
  input logic             cut_rise,
  input logic             low_wrap,
  input logic             busy,
  input logic             gate,
  input logic             done,
  input logic             ovf_err,
  input logic [CNT_W-1:0] low_count,
  input logic [OVF_W-1:0] ovf_count
);

  p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy && !clear) |=> (busy && !gate && !done));

  p_gate_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);

  p_done_at_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($fell(gate) && !busy));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && cut_rise && !clear) |=> (low_count == CNT_W'($past(low_count) + 1'b1)));

  p_hold_when_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !clear) |=> ($stable(low_count) && $stable(ovf_count)));

  p_wrap_steps_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wrap && !clear && !(&ovf_count)) |=> (ovf_count == OVF_W'($past(ovf_count) + 1'b1)));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clear) |=> ovf_err);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (low_count == '0 && ovf_count == '0 && !busy && !gate && !done && !ovf_err));

  p_idle_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !arm) |=> !gate);

endmodule

bind pps_gated_counter pgc_checker #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .arm      (arm),
  .cut_rise (cut_rise),
  .low_wrap (low_wrap),
  .busy     (busy),
  .gate     (gate),
  .done     (done),
  .ovf_err  (ovf_err),
  .low_count(low_count),
  .ovf_count(ovf_count)
);

// File: tb/pps_gated_counter_test.sv
module pps_gated_counter_test;

  localparam int SW = 4;  // narrow instance low word
  localparam int SO = 3;  // narrow instance overflow word

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cut_in = 1'b0, ref_in = 1'b0, arm = 1'b0, clear = 1'b0;

  logic [31:0] tot;
  logic [15:0] low, ovf;
  logic        err, busy, gate, done;
  logic [SW+SO-1:0] s_tot;
  logic [SW-1:0]    s_low;
  logic [SO-1:0]    s_ovf;
  logic             s_err, s_busy, s_gate, s_done;

  int errors = 0;
  int checks = 0;

  // Reference model state
  int     m_phase = 0;  // 0 idle, 1 armed, 2 open
  bit     m_done = 0;
  longint m_n = 0;
  bit     rh[3] = '{0, 0, 0};
  bit     ch[3] = '{0, 0, 0};

  always #2 clk = ~clk;  // 250 MHz

  pps_gated_counter uut (
    .clk(clk), .rst_n(rst_n), .cut_in(cut_in), .ref_in(ref_in), .arm(arm), .clear(clear),
    .total_count(tot), .low_count(low), .ovf_count(ovf), .ovf_err(err),
    .busy(busy), .gate(gate), .done(done)
  );

  pps_gated_counter #(.CNT_W(SW), .OVF_W(SO)) uut_sat (
    .clk(clk), .rst_n(rst_n), .cut_in(cut_in), .ref_in(ref_in), .arm(arm), .clear(clear),
    .total_count(s_tot), .low_count(s_low), .ovf_count(s_ovf), .ovf_err(s_err),
    .busy(s_busy), .gate(s_gate), .done(s_done)
  );

  function automatic longint exp_low(longint n, int cw);
    return n % (longint'(1) << cw);
  endfunction

  function automatic longint exp_ovf(longint n, int cw, int ow);
    longint q = n / (longint'(1) << cw);
    longint mx = (longint'(1) << ow) - 1;
    return (q > mx) ? mx : q;
  endfunction

  function automatic longint exp_err(longint n, int cw, int ow);
    return ((n / (longint'(1) << cw)) > ((longint'(1) << ow) - 1)) ? 1 : 0;
  endfunction

  function automatic longint exp_tot(longint n, int cw, int ow);
    return exp_ovf(n, cw, ow) * (longint'(1) << cw) + exp_low(n, cw);
  endfunction

  task automatic chk(string what, string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk("busy", req, busy, m_phase != 0);
    chk("gate", req, gate, m_phase == 2);
    chk("done", req, done, m_done);
    chk("low", req, low, exp_low(m_n, 16));
    chk("ovf R5", req, ovf, exp_ovf(m_n, 16, 16));
    chk("total R6", req, tot, exp_tot(m_n, 16, 16));
    chk("err R7", req, err, exp_err(m_n, 16, 16));
    chk("sat busy", req, s_busy, m_phase != 0);
    chk("sat gate", req, s_gate, m_phase == 2);
    chk("sat done", req, s_done, m_done);
    chk("sat low", req, s_low, exp_low(m_n, SW));
    chk("sat ovf R5", req, s_ovf, exp_ovf(m_n, SW, SO));
    chk("sat total R6", req, s_tot, exp_tot(m_n, SW, SO));
    chk("sat err R7", req, s_err, exp_err(m_n, SW, SO));
  endtask

  // One system cycle: drive at the falling edge, update the model for the next rising edge
  task automatic cyc(bit r, bit c, bit a, bit cl);
    bit rre, cre;
    @(negedge clk);
    ref_in = r; cut_in = c; arm = a; clear = cl;
    rre = rh[1] && !rh[2];
    cre = ch[1] && !ch[2];
    if (cl) begin
      m_n = 0; m_phase = 0; m_done = 0;
    end else begin
      if (m_phase == 2 && cre) m_n++;
      if (m_phase != 0 && rre) begin
        if (m_phase == 1) m_phase = 2;
        else begin m_phase = 0; m_done = 1; end
      end else if (m_phase == 0 && a) begin
        m_phase = 1; m_done = 0;
      end
    end
    rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = r;
    ch[2] = ch[1]; ch[1] = ch[0]; ch[0] = c;
    @(posedge clk);
  endtask

  task automatic run(bit r, bit c, bit a, bit cl, string req);
    cyc(r, c, a, cl);
    #1;
    check_all(req);
  endtask

  // Random clock-under-test activity for n cycles, reference held at level r
  task automatic noise(int n, bit r, int dens, string req);
    for (int i = 0; i < n; i++) run(r, (($urandom % 100) < dens), 1'b0, 1'b0, req);
  endtask

  // Complete acquisition: arm, opening pulse, random activity, closing pulse
  task automatic acquire(int len, int dens, bit do_clear, string req);
    if (do_clear) run(0, 0, 0, 1, "R8");
    run(0, cut_in, 1, 0, "R2");
    noise(3, 0, dens, req);
    noise(2, 1, dens, "R3");
    noise(len, 0, dens, req);
    noise(2, 1, dens, "R3");
    noise(6, 0, dens, req);
  endtask

  initial begin
    void'($urandom(32'd7731));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; check_all("R1");

    // R2: arm raises busy, gate waits for reference
    run(0, 0, 1, 0, "R2");
    noise(4, 0, 50, "R2");
    // R3 timing of opening edge, cycle by cycle
    run(1, 1, 0, 0, "R3");
    run(1, 0, 0, 0, "R3");
    run(0, 1, 0, 0, "R3");
    run(0, 0, 0, 0, "R3");
    noise(30, 0, 60, "R4");
    // R10: arm while gating is ignored
    run(0, 1, 1, 0, "R10");
    noise(10, 0, 60, "R10");
    // R4 boundary: cut edge aligned with the closing reference edge is counted
    run(0, 0, 0, 0, "R4");
    run(1, 1, 0, 0, "R4");
    run(1, 0, 0, 0, "R3");
    noise(6, 0, 70, "R4");

    // R9: reference pulses while idle
    noise(3, 1, 50, "R9");
    noise(3, 0, 50, "R9");
    noise(3, 1, 50, "R9");
    noise(5, 0, 50, "R9");

    // R11: second acquisition without clear accumulates
    acquire(40, 50, 1'b0, "R11");

    // R8: clear during gating, also wins over arm
    acquire(0, 50, 1'b1, "R4");
    run(0, 0, 1, 0, "R2");
    noise(3, 0, 50, "R2");
    noise(2, 1, 50, "R3");
    noise(20, 0, 60, "R4");
    run(0, 1, 1, 1, "R8");
    noise(6, 0, 60, "R8");

    // Constrained random acquisitions
    for (int k = 0; k < 12; k++) begin
      acquire(20 + ($urandom % 300), 10 + ($urandom % 90), ($urandom % 3) != 0, "R4");
    end

    // R5 and R7: long acquisition past one low-word wrap; narrow instance saturates
    run(0, 0, 0, 1, "R8");
    run(0, 0, 1, 0, "R2");
    noise(3, 0, 0, "R2");
    noise(2, 1, 0, "R3");
    noise(2, 0, 0, "R5");
    for (int i = 0; i < 65540; i++) begin
      cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0);
    end
    noise(2, 1, 0, "R5");
    noise(5, 0, 0, "R7");
    chk("low after wrap", "R5", low, 4);
    chk("ovf after wrap", "R5", ovf, 1);
    chk("sat flag", "R7", s_err, 1);
    chk("sat ovf held", "R7", s_ovf, 7);
    // R7: flag stays after more idle cycles, drops on clear
    noise(5, 0, 50, "R7");
    run(0, 0, 0, 1, "R8");
    chk("err cleared", "R8", s_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule